// File: doc/BRIEF.md
# Elapsed-Time Clock with Alarm and Periodic Interrupts

This block keeps running time as a day count plus hours, minutes and seconds. Its time base is a slow reference clock delivered as a one-cycle strobe in the system clock domain. A prescaler turns the selected reference rate into an exact 512 Hz fast tick. A nine-stage binary divider takes that tick down to 1 Hz, and at 1 Hz the seconds, minutes, hours and days advance with the usual wraps. Software reads and writes the time, the alarm and the interrupt registers over a plain 16-bit register bus with byte offsets.

Three kinds of event set status flags: the running time reaching the alarm value, the once-per-second update, and nine periodic rates from 2 Hz to 512 Hz. Software clears each flag by writing a 1 to it. One interrupt line is raised while any flag that software has enabled is pending. A control register turns the clock on or off and selects among three reference rates.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset every register reads 0: hour/minute (offset 0x00), seconds (0x04), day (0x20), control (0x10) and status (0x14). The interrupt output is low.
- R2: In the control register (0x10), bit 7 turns the clock on and bits [6:5] choose the reference rate: 00 is 32768 Hz, 01 is 32000 Hz, 10 is 38400 Hz, and 11 is treated as 32768 Hz. Only bits [7:5] read back. All other bits read 0.
- R3: While control bit 7 is 0, reference strobes change neither the time nor the status flags.
- R4: A write loads the time registers directly. Offset 0x00 packs the hour in bits [15:8] and the minute in bits [7:0]. Offset 0x04 holds the seconds and 0x20 the day. The alarm registers sit at 0x08 (hour/minute, same packing), 0x0C (seconds) and 0x24 (day).
- R5: The fast tick is exact. At 38400 Hz it arrives every 75 strobes. At 32768 Hz one second takes exactly 32768 strobes, and at 32000 Hz exactly 32000 strobes. A write to the seconds register restarts the prescaler and the sub-second divider.
- R6: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0. The hour wrap increments the day count.
- R7: Status bits 7 through 15 are the periodic flags for 2, 4, 8, 16, 32, 64, 128, 256 and 512 Hz in that order. Each one sets when the sub-second count, after advancing, has its low bits below that rate's period at zero. Bit 4 sets when the seconds advance.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A flag whose event arrives in the same cycle as its clear stays set. Writing 0xFFFF clears every flag.
- R9: The enable register (0x18) holds only bits 2, 4 and 7 to 15. The interrupt output is high exactly when some status bit and its enable bit are both 1. Bit 0 never sets.
- R10: Status bit 2 sets when the day, hour, minute and second become equal to the alarm registers.
- R11: Reads of unused offsets (for example 0x1C and 0x28) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle strobe per reference clock period |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data; 0 when no read is selected |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler remainder or divider count usually stays invisible at first. It shows up as a periodic flag arriving one strobe early or late, and an error in the 32000 Hz accumulator can take most of a second to move the seconds count. For that reason the tests count strobes up to the exact boundary and read the registers on both sides of it. A faulty wrap or carry shows up only at 59 seconds, 59 minutes or 23 hours, so the time is loaded right next to those points. A bad alarm compare or clear shows on the status register and the interrupt one cycle after the event.

// File: rtl/rtc_tk_pkg.sv
`timescale 1ns/1ps
package rtc_tk_pkg;
  parameter int ADDR_W  = 6;
  parameter int DATA_W  = 16;
  parameter int SUB_W   = 9;   // fast ticks per second = 2**SUB_W
  parameter int SEC_W   = 6;
  parameter int MIN_W   = 6;
  parameter int HOUR_W  = 5;
  parameter int DAY_W   = 16;
  localparam int NUM_PER   = SUB_W;          // periodic rates 2 Hz .. 512 Hz
  localparam int FAST_STEP = 1 << SUB_W;

  localparam logic [ADDR_W-1:0] OFF_HM   = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_SEC  = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_AHM  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_ASEC = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_STAT = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_IEN  = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_DAY  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_ADAY = 6'h24;

  localparam int BIT_ALARM = 2;
  localparam int BIT_SEC   = 4;
  localparam int BIT_PER0  = 7;
  localparam logic [DATA_W-1:0] STAT_MASK = 16'hFF94;

  typedef struct packed {
    logic              run;
    logic [1:0]        rateSel;
    logic              loadSec;
    logic              loadHm;
    logic              loadDay;
    logic [DATA_W-1:0] data;
  } tkStrobe_t;

  typedef struct packed {
    logic [NUM_PER-1:0] perTick;
    logic               secTick;
    logic [DAY_W-1:0]   day;
    logic [HOUR_W-1:0]  hour;
    logic [MIN_W-1:0]   min;
    logic [SEC_W-1:0]   sec;
  } tkEvent_t;
endpackage

// File: rtl/rtc_tk_datapath.sv
`timescale 1ns/1ps
module rtc_tk_datapath
  import rtc_tk_pkg::*;
#(
  parameter int RATE_A = 32768,
  parameter int RATE_B = 32000,
  parameter int RATE_C = 38400
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      refTick,
  input  tkStrobe_t strb,
  output tkEvent_t  evt
);
  localparam int ACC_W = $clog2(RATE_A + RATE_B + RATE_C + FAST_STEP) + 1;

  logic [ACC_W-1:0]  acc, accSum, rateVal;
  logic [SUB_W-1:0]  subCnt, subNext;
  logic [SEC_W-1:0]  secQ;
  logic [MIN_W-1:0]  minQ;
  logic [HOUR_W-1:0] hourQ;
  logic [DAY_W-1:0]  dayQ;
  logic tickFast, secTick, secWrap, minWrap, hourWrap, stepRef;

  always_comb begin
    unique case (strb.rateSel)
      2'b01:   rateVal = ACC_W'(RATE_B);
      2'b10:   rateVal = ACC_W'(RATE_C);
      default: rateVal = ACC_W'(RATE_A);
    endcase
  end

  assign stepRef  = strb.run && refTick && !strb.loadSec;
  assign accSum   = acc + ACC_W'(FAST_STEP);
  assign tickFast = stepRef && (accSum >= rateVal);
  assign subNext  = subCnt + 1'b1;
  assign secTick  = tickFast && (subNext == '0);
  assign secWrap  = secTick && (secQ >= SEC_W'(59));
  assign minWrap  = secWrap && (minQ >= MIN_W'(59));
  assign hourWrap = minWrap && (hourQ >= HOUR_W'(23));

  for (genvar k = 0; k < NUM_PER; k++) begin : g_per
    if (k == NUM_PER - 1) begin : g_full
      assign evt.perTick[k] = tickFast;
    end else begin : g_div
      assign evt.perTick[k] = tickFast && (subNext[NUM_PER-2-k:0] == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      subCnt <= '0;
    end else if (strb.loadSec) begin
      acc    <= '0;
      subCnt <= '0;
    end else if (stepRef) begin
      acc <= tickFast ? (accSum - rateVal) : accSum;
      if (tickFast) subCnt <= subNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ  <= '0;
      minQ  <= '0;
      hourQ <= '0;
      dayQ  <= '0;
    end else begin
      if (strb.loadSec)  secQ <= strb.data[SEC_W-1:0];
      else if (secTick)  secQ <= secWrap ? '0 : secQ + 1'b1;

      if (strb.loadHm) begin
        minQ  <= strb.data[MIN_W-1:0];
        hourQ <= strb.data[8 +: HOUR_W];
      end else begin
        if (secWrap) minQ  <= minWrap ? '0 : minQ + 1'b1;
        if (minWrap) hourQ <= hourWrap ? '0 : hourQ + 1'b1;
      end

      if (strb.loadDay)  dayQ <= strb.data[DAY_W-1:0];
      else if (hourWrap) dayQ <= dayQ + 1'b1;
    end
  end

  assign evt.secTick = secTick;
  assign evt.sec     = secQ;
  assign evt.min     = minQ;
  assign evt.hour    = hourQ;
  assign evt.day     = dayQ;
endmodule

// File: rtl/rtc_tk_ctrl.sv
`timescale 1ns/1ps
module rtc_tk_ctrl
  import rtc_tk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  tkEvent_t          evt,
  output tkStrobe_t         strb,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] enableQ,
  output logic              irq
);
  logic              runQ;
  logic [1:0]        rateQ;
  logic [SEC_W-1:0]  almSec;
  logic [MIN_W-1:0]  almMin;
  logic [HOUR_W-1:0] almHour;
  logic [DAY_W-1:0]  almDay;
  logic              matchPrev, matchNow, alarmRise, wrEn;
  logic [DATA_W-1:0] setVec, clrVec, hmNow, hmAlm;

  assign wrEn = busSel && busWr;

  assign strb.run     = runQ;
  assign strb.rateSel = rateQ;
  assign strb.loadSec = wrEn && (busAddr == OFF_SEC);
  assign strb.loadHm  = wrEn && (busAddr == OFF_HM);
  assign strb.loadDay = wrEn && (busAddr == OFF_DAY);
  assign strb.data    = busWdata;

  assign matchNow  = (evt.day == almDay) && (evt.hour == almHour) &&
                     (evt.min == almMin) && (evt.sec == almSec);
  assign alarmRise = matchNow && !matchPrev;

  always_comb begin
    setVec = '0;
    setVec[BIT_PER0 +: NUM_PER] = evt.perTick;
    setVec[BIT_SEC]   = evt.secTick;
    setVec[BIT_ALARM] = alarmRise;
    clrVec = (wrEn && (busAddr == OFF_STAT)) ? busWdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      rateQ     <= '0;
      almSec    <= '0;
      almMin    <= '0;
      almHour   <= '0;
      almDay    <= '0;
      statusQ   <= '0;
      enableQ   <= '0;
      matchPrev <= 1'b1;
    end else begin
      matchPrev <= matchNow;
      statusQ   <= ((statusQ & ~clrVec) | setVec) & STAT_MASK;
      if (wrEn) begin
        unique case (busAddr)
          OFF_CTRL: begin
            runQ  <= busWdata[7];
            rateQ <= busWdata[6:5];
          end
          OFF_AHM: begin
            almMin  <= busWdata[MIN_W-1:0];
            almHour <= busWdata[8 +: HOUR_W];
          end
          OFF_ASEC: almSec  <= busWdata[SEC_W-1:0];
          OFF_ADAY: almDay  <= busWdata[DAY_W-1:0];
          OFF_IEN:  enableQ <= busWdata & STAT_MASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    hmNow = '0;
    hmNow[8 +: HOUR_W] = evt.hour;
    hmNow[MIN_W-1:0]   = evt.min;
    hmAlm = '0;
    hmAlm[8 +: HOUR_W] = almHour;
    hmAlm[MIN_W-1:0]   = almMin;
    busRdata = '0;
    if (busSel && !busWr) begin
      unique case (busAddr)
        OFF_HM:   busRdata = hmNow;
        OFF_SEC:  busRdata = DATA_W'(evt.sec);
        OFF_AHM:  busRdata = hmAlm;
        OFF_ASEC: busRdata = DATA_W'(almSec);
        OFF_CTRL: busRdata = {8'h00, runQ, rateQ, 5'b00000};
        OFF_STAT: busRdata = statusQ;
        OFF_IEN:  busRdata = enableQ;
        OFF_DAY:  busRdata = DATA_W'(evt.day);
        OFF_ADAY: busRdata = DATA_W'(almDay);
        default:  busRdata = '0;
      endcase
    end
  end

  assign irq = |(statusQ & enableQ);
endmodule

// File: rtl/rtc_timekeeper.sv
`timescale 1ns/1ps
module rtc_timekeeper
  import rtc_tk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  tkStrobe_t         strb;
  tkEvent_t          evt;
  logic [DATA_W-1:0] statusQ, enableQ;

  rtc_tk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .evt      (evt),
    .strb     (strb),
    .busRdata (busRdata),
    .statusQ  (statusQ),
    .enableQ  (enableQ),
    .irq      (irq)
  );

  rtc_tk_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .strb    (strb),
    .evt     (evt)
  );
endmodule

// File: rtl/rtc_timekeeper_chk.sv
`timescale 1ns/1ps
module rtc_timekeeper_chk
  import rtc_tk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              irq,
  input logic              runOn,
  input logic              fastTick,
  input logic              secTick,
  input logic [SEC_W-1:0]  secNow,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] enableQ
);
  logic anyWr;
  assign anyWr = busSel && busWr;

  // R2
  run_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anyWr && busAddr == OFF_CTRL && busWdata[7]) |=> runOn);

  // R3
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runOn && !anyWr) |=> $stable(secNow));

  // R6
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && secNow == SEC_W'(59) && !anyWr) |=> (secNow == '0));

  // R7
  fast_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    fastTick |=> statusQ[BIT_PER0 + NUM_PER - 1]);

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anyWr && busAddr == OFF_STAT && busWdata[BIT_SEC] && !secTick)
      |=> !statusQ[BIT_SEC]);

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0) |-> !irq);

  // R9
  no_stopwatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusQ[0]);
endmodule

bind rtc_timekeeper rtc_timekeeper_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .irq      (irq),
  .runOn    (strb.run),
  .fastTick (evt.perTick[rtc_tk_pkg::NUM_PER-1]),
  .secTick  (evt.secTick),
  .secNow   (evt.sec),
  .statusQ  (statusQ),
  .enableQ  (enableQ)
);

// File: tb/rtc_timekeeper_bench.sv
`timescale 1ns/1ps
module rtc_timekeeper_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  logic [15:0] expQ[$];
  string       tagQ[$];
  logic [15:0] sampleVal;
  event        sampleEv;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  rtc_timekeeper u_rtc_timekeeper (
    .clk(clk), .rstN(rstN), .refTick(refTick), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  // monitor: pops the expected item for each produced sample
  initial begin
    forever begin
      @(sampleEv);
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard empty: actual %h expected none", sampleVal);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (sampleVal !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, sampleVal, e);
        end
      end
    end
  end

  task automatic busWrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic chkRead(input logic [5:0] a, input logic [15:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    sampleVal = busRdata;
    ->sampleEv;
    #1;
    busSel = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string t);
    expQ.push_back({15'b0, e});
    tagQ.push_back(t);
    @(negedge clk);
    sampleVal = {15'b0, irq};
    ->sampleEv;
  endtask

  task automatic runRef(input int n);
    @(negedge clk);
    refTick = 1'b1;
    repeat (n) @(negedge clk);
    refTick = 1'b0;
  endtask

  task automatic finishRun();
    #1;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d items left expected 0", expQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkRead(6'h00, 16'h0000, "R1 hour/minute");
    chkRead(6'h04, 16'h0000, "R1 seconds");
    chkRead(6'h20, 16'h0000, "R1 day");
    chkRead(6'h10, 16'h0000, "R1 control");
    chkRead(6'h14, 16'h0000, "R1 status");
    chkIrq(1'b0, "R1 irq");

    // R3 clock off: strobes ignored
    runRef(100);
    chkRead(6'h04, 16'h0000, "R3 seconds hold");
    chkRead(6'h14, 16'h0000, "R3 no flags");

    // R2 control readback
    busWrite(6'h10, 16'hFFFF);
    chkRead(6'h10, 16'h00E0, "R2 only [7:5] kept");
    busWrite(6'h10, 16'h00C0);
    chkRead(6'h10, 16'h00C0, "R2 run at 38400");

    // R4 direct loads and packing
    busWrite(6'h00, 16'h0A1B);
    busWrite(6'h04, 16'h0005);
    busWrite(6'h20, 16'h0123);
    chkRead(6'h00, 16'h0A1B, "R4 hour/minute");
    chkRead(6'h04, 16'h0005, "R4 seconds");
    chkRead(6'h20, 16'h0123, "R4 day");

    // R5 38400 Hz: fast tick every 75 strobes; R7 periodic order
    busWrite(6'h04, 16'h0005);
    busWrite(6'h14, 16'hFFFF);
    runRef(74);
    chkRead(6'h14, 16'h0000, "R5 no tick at 74");
    runRef(1);
    chkRead(6'h14, 16'h8000, "R5 512 Hz at 75");
    runRef(75);
    chkRead(6'h14, 16'hC000, "R7 256 Hz at second tick");

    // R8 write-one-to-clear, R9 enable and irq
    busWrite(6'h14, 16'h8000);
    chkRead(6'h14, 16'h4000, "R8 clear only bit 15");
    busWrite(6'h18, 16'h4000);
    chkIrq(1'b1, "R9 irq enabled pending");
    busWrite(6'h18, 16'h8000);
    chkIrq(1'b0, "R9 irq masked");
    busWrite(6'h18, 16'hFFFF);
    chkRead(6'h18, 16'hFF94, "R9 enable mask");
    busWrite(6'h14, 16'hFFFF);
    chkRead(6'h14, 16'h0000, "R8 clear all");
    chkIrq(1'b0, "R8 irq after clear");
    busWrite(6'h18, 16'h0000);

    // R11 unused offsets
    busWrite(6'h1C, 16'hFFFF);
    busWrite(6'h28, 16'hFFFF);
    chkRead(6'h1C, 16'h0000, "R11 read 0x1C");
    chkRead(6'h28, 16'h0000, "R11 read 0x28");
    chkRead(6'h14, 16'h0000, "R11 status untouched");
    chkRead(6'h18, 16'h0000, "R11 enable untouched");
    chkRead(6'h10, 16'h00C0, "R11 control untouched");
    chkRead(6'h04, 16'h0005, "R11 seconds untouched");

    // R7 all periodic flags after half a second at 32768 Hz
    busWrite(6'h10, 16'h0080);
    busWrite(6'h04, 16'h0000);
    busWrite(6'h14, 16'hFFFF);
    runRef(16384);
    chkRead(6'h14, 16'hFF80, "R7 2..512 Hz set");
    chkRead(6'h04, 16'h0000, "R7 no second yet");
    busWrite(6'h14, 16'hFFFF);
    runRef(16383);
    chkRead(6'h04, 16'h0000, "R5 32768 minus one");
    runRef(1);
    chkRead(6'h04, 16'h0001, "R5 32768 exact second");
    chkRead(6'h14, 16'hFF90, "R7 1 Hz flag");

    // R6 full rollover at 32000 Hz; R10 alarm
    busWrite(6'h10, 16'h00A0);
    busWrite(6'h20, 16'h0007);
    busWrite(6'h00, 16'h173B);
    busWrite(6'h04, 16'h003B);
    busWrite(6'h24, 16'h0008);
    busWrite(6'h08, 16'h0000);
    busWrite(6'h0C, 16'h0001);
    chkRead(6'h24, 16'h0008, "R4 alarm day");
    chkRead(6'h0C, 16'h0001, "R4 alarm seconds");
    busWrite(6'h14, 16'hFFFF);
    busWrite(6'h18, 16'h0004);
    runRef(31999);
    chkRead(6'h04, 16'h003B, "R5 32000 minus one");
    chkRead(6'h20, 16'h0007, "R6 day before wrap");
    runRef(1);
    chkRead(6'h04, 16'h0000, "R6 seconds wrap");
    chkRead(6'h00, 16'h0000, "R6 hour/minute wrap");
    chkRead(6'h20, 16'h0008, "R6 day increment");
    chkRead(6'h14, 16'hFF90, "R10 no alarm yet");
    chkIrq(1'b0, "R10 irq quiet");
    busWrite(6'h14, 16'hFFFF);
    runRef(32000);
    chkRead(6'h04, 16'h0001, "R5 32000 exact second");
    chkRead(6'h14, 16'hFF94, "R10 alarm flag");
    chkIrq(1'b1, "R10 alarm irq");

    done = 1'b1;
    finishRun();
  end
endmodule